// File: doc/BRIEF.md
# Three-Wire Handshake Host Transfer Engine

This block is the host end of a byte-serial link to a system-controller microcontroller. Alongside an external byte shifter it uses three handshake lines: a transfer-request input from the controller and two host outputs, byte-acknowledge and transfer-in-progress. All three are active low. The engine takes one outbound request at a time. A request holds up to `REQ_MAX` bytes, a length and a flag that says whether a reply follows. The engine sends the bytes through the shifter and then gathers any reply. Packets that the controller starts on its own go to a separate unsolicited output.

After reset the engine runs a synchronisation handshake with the controller. It accepts no traffic until that handshake completes. The first byte of a request selects a packet type. Replies to the bus-packet type (0x00) are trimmed before they are handed back.

When both sides try to start a transfer at once, the engine yields to the controller. It reads the controller's packet first and then retries its own request from byte 0. Received packets are kept in a capped buffer of `RX_DEPTH` bytes, and any bytes beyond the cap are dropped.

Top module: `hsk_xfer_engine`

## Requirements
- R1: While reset is held, `ack_n` and `tip_n` are 1, `sh_dir_out`, `req_busy`, `done`, `uns_valid`, `sync_ok` and `sync_fail` are 0.
- R2: After reset both host lines stay negated for `SETTLE_CYC` cycles, then `ack_n` goes low. Once `treq_n` low and a `sh_done` have been seen, `ack_n` returns high. Once `treq_n` high and a further `sh_done` have been seen, `sync_ok` becomes 1. `tip_n` stays 1 until `sync_ok`.
- R3: If any wait of the handshake lasts `TMO_CYC` cycles, `sync_fail` becomes 1 and stays 1, both host lines stay negated and `sync_ok` stays 0.
- R4: A request is rejected if its length is below 2, its length is above `REQ_MAX`, or its byte 0 exceeds 0x01. A rejected request gives `done` with `done_err` at 1 on the cycle after `req_start`, leaves `req_busy` at 0 and starts no transfer.
- R5: A pending request starts only from idle and only while `treq_n` is 1. On start, `sh_dir_out` goes to 1, `sh_load` pulses with byte 0 on `sh_tx_byte`, and `tip_n` goes low. The bytes of `req_data` are packed with byte i at bits [8i+7:8i].
- R6: After the first byte, each `sh_done` with bytes left loads the next byte and inverts `ack_n`.
- R7: A `sh_done` while the first byte is out and `treq_n` is low is a collision. `sh_dir_out` goes to 0, `tip_n` and `ack_n` go to 1, and `req_busy` stays 1.
- R8: The `sh_done` after the last byte sets `sh_dir_out` to 0 and `tip_n` and `ack_n` to 1. Without a reply expected, `done` pulses with `done_err` at 0 and `req_busy` drops.
- R9: When a reply is expected, the next `sh_done` is discarded and sets `tip_n` low. Each later `sh_done` stores `sh_rx_byte`. A stored byte taken with `treq_n` low inverts `ack_n`; one taken with `treq_n` high sets both host lines to 1. The following `sh_done` pulses `done` and presents the reply on `rsp_data`/`rsp_len`.
- R10: A `sh_done` in idle starts an unsolicited packet, gathered in the same way as in R9. It finishes with a `uns_valid` pulse carrying `uns_data`/`uns_len`. The starting byte is not stored.
- R11: A packet keeps only its first `RX_DEPTH` bytes, and the reported length never exceeds `RX_DEPTH`.
- R12: For a request whose byte 0 is 0x00, the reply length becomes 0 if it is 2 or less, or if bit 1 of reply byte 1 is set. Otherwise the first two reply bytes are removed. Replies to type 0x01 are returned whole.
- R13: On the `sh_done` that closes a packet, a retry request with `treq_n` high starts sending in that same step. If `treq_n` is low instead, `tip_n` goes low at once and a new unsolicited packet begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Offer a request (taken when no request is pending) |
| req_data | input | REQ_MAX*8 | Request bytes, byte i at [8i+7:8i] |
| req_len | input | RLW | Request length in bytes |
| req_reply | input | 1 | A reply follows the request |
| req_busy | output | 1 | A request is pending |
| done | output | 1 | Request completion pulse |
| done_err | output | 1 | Completion was a rejection |
| rsp_data | output | RX_DEPTH*8 | Reply bytes, byte i at [8i+7:8i] |
| rsp_len | output | RCW | Reply length after trimming |
| uns_valid | output | 1 | Unsolicited packet pulse |
| uns_data | output | RX_DEPTH*8 | Unsolicited packet bytes |
| uns_len | output | RCW | Unsolicited packet length |
| treq_n | input | 1 | Transfer request from controller, active low |
| ack_n | output | 1 | Byte acknowledge, active low |
| tip_n | output | 1 | Transfer in progress, active low |
| sh_dir_out | output | 1 | Shifter direction, 1 = shift out |
| sh_load | output | 1 | Load `sh_tx_byte` into the shifter |
| sh_tx_byte | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shifter finished a byte |
| sh_rx_byte | input | 8 | Byte the shifter received |
| sync_ok | output | 1 | Start-up handshake complete |
| sync_fail | output | 1 | Start-up handshake timed out |

## Verification
The checker watches several rules on every cycle:
- no transfer-in-progress before synchronisation;
- quiet lines after a failed handshake;
- no busy flag beside a rejection;
- every shifter load made in the output direction with transfer-in-progress low;
- an acknowledge inversion on every load after the first;
- reported lengths within the cap;
- no overlap of reply and unsolicited completions.

The bench scenarios cover what only a whole sequence can show:
- the order and content of the synchronisation steps;
- the bytes and lengths of trimmed and untrimmed replies;
- the dropping of bytes beyond the cap;
- a collision followed by a retry from byte 0;
- back-to-back unsolicited packets;
- the handshake timeout.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_FIRST,
      ENG_SEND,
      ENG_READ,
      ENG_RDONE,
      ENG_AWAIT
   } eng_st_t;

   typedef enum logic [2:0] {
      SY_SETTLE,
      SY_ACK_ON,
      SY_ACK_OFF,
      SY_READY,
      SY_FAIL
   } sync_st_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync
   import hsk_pkg::*;
#(
   parameter int SETTLE_CYC = 400000,
   parameter int TMO_CYC    = 10000000,
   localparam int CMAX      = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC,
   localparam int CW        = $clog2(CMAX + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic treq_n,
   input  logic sh_done,
   output logic ack_n,
   output logic ready,
   output logic fail
);
   sync_st_t      st;
   logic [CW-1:0] cnt;
   logic          seen_lvl, seen_done;
   logic          want_lvl, nxt_lvl, nxt_done;

   // level awaited in each wait step: request asserted, then released
   assign want_lvl = (st == SY_ACK_ON) ? !treq_n : treq_n;
   assign nxt_lvl  = seen_lvl | want_lvl;
   assign nxt_done = seen_done | sh_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SY_SETTLE;
         cnt       <= '0;
         seen_lvl  <= 1'b0;
         seen_done <= 1'b0;
         ack_n     <= 1'b1;
         ready     <= 1'b0;
         fail      <= 1'b0;
      end else begin
         case (st)
            SY_SETTLE: begin
               if (cnt == CW'(SETTLE_CYC - 1)) begin
                  st    <= SY_ACK_ON;
                  cnt   <= '0;
                  ack_n <= 1'b0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            SY_ACK_ON, SY_ACK_OFF: begin
               if (nxt_lvl && nxt_done) begin
                  cnt       <= '0;
                  seen_lvl  <= 1'b0;
                  seen_done <= 1'b0;
                  if (st == SY_ACK_ON) begin
                     st    <= SY_ACK_OFF;
                     ack_n <= 1'b1;
                  end else begin
                     st    <= SY_READY;
                     ready <= 1'b1;
                  end
               end else if (cnt == CW'(TMO_CYC - 1)) begin
                  st    <= SY_FAIL;
                  ack_n <= 1'b1;
                  fail  <= 1'b1;
               end else begin
                  cnt       <= cnt + CW'(1);
                  seen_lvl  <= nxt_lvl;
                  seen_done <= nxt_done;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hsk_rxbuf.sv
module hsk_rxbuf
   import hsk_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr,
   input  logic [BYTE_W-1:0]       din,
   output logic [DEPTH*BYTE_W-1:0] data,
   output logic [CNTW-1:0]         cnt
);
   logic room;
   assign room = (cnt < CNTW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (wr && room)  cnt <= cnt + CNTW'(1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data[i*BYTE_W +: BYTE_W] <= '0;
         else if (wr && !clr && (cnt == CNTW'(i)))
            data[i*BYTE_W +: BYTE_W] <= din;
      end
   end
endmodule

// File: rtl/hsk_trim.sv
module hsk_trim
   import hsk_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNTW = $clog2(DEPTH + 1)
)(
   input  logic                    hit,
   input  logic [DEPTH*BYTE_W-1:0] din,
   input  logic [CNTW-1:0]         len,
   output logic [DEPTH*BYTE_W-1:0] dout,
   output logic [CNTW-1:0]         lout
);
   always_comb begin
      dout = din;
      lout = len;
      if (hit) begin
         if ((len <= CNTW'(2)) || din[BYTE_W + 1]) begin
            lout = '0;
         end else begin
            lout = len - CNTW'(2);
            dout = din >> (2 * BYTE_W);
         end
      end
   end
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
   import hsk_pkg::*;
#(
   parameter int          REQ_MAX    = 8,
   parameter int          RX_DEPTH   = 16,
   parameter logic [7:0]  MAX_TYPE   = 8'h01,
   parameter logic [7:0]  TRIM_TYPE  = 8'h00,
   parameter bit          TRIM_EN    = 1'b1,
   parameter int          SETTLE_CYC = 400000,
   parameter int          TMO_CYC    = 10000000,
   localparam int         RLW        = $clog2(REQ_MAX + 1),
   localparam int         RCW        = $clog2(RX_DEPTH + 1)
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_start,
   input  logic [REQ_MAX*BYTE_W-1:0]  req_data,
   input  logic [RLW-1:0]             req_len,
   input  logic                       req_reply,
   output logic                       req_busy,
   output logic                       done,
   output logic                       done_err,
   output logic [RX_DEPTH*BYTE_W-1:0] rsp_data,
   output logic [RCW-1:0]             rsp_len,
   output logic                       uns_valid,
   output logic [RX_DEPTH*BYTE_W-1:0] uns_data,
   output logic [RCW-1:0]             uns_len,
   input  logic                       treq_n,
   output logic                       ack_n,
   output logic                       tip_n,
   output logic                       sh_dir_out,
   output logic                       sh_load,
   output logic [BYTE_W-1:0]          sh_tx_byte,
   input  logic                       sh_done,
   input  logic [BYTE_W-1:0]          sh_rx_byte,
   output logic                       sync_ok,
   output logic                       sync_fail
);
   initial begin
      if (REQ_MAX < 2)  $fatal(1, "REQ_MAX must be at least 2");
      if (RX_DEPTH < 3) $fatal(1, "RX_DEPTH must be at least 3");
      if (SETTLE_CYC < 1 || TMO_CYC < 2) $fatal(1, "sync timing out of range");
   end

   // ---------------- start-up handshake ----------------
   logic sy_ack_n;
   hsk_sync #(.SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)) u_sync (
      .clk(clk), .rst_n(rst_n), .treq_n(treq_n), .sh_done(sh_done),
      .ack_n(sy_ack_n), .ready(sync_ok), .fail(sync_fail)
   );

   // ---------------- engine state ----------------
   eng_st_t                   st;
   logic                      pend, rq_rexp, to_reply;
   logic [REQ_MAX*BYTE_W-1:0] rq_data;
   logic [RLW-1:0]            rq_len, idx;
   logic                      e_ack_n, e_tip_n;

   // ---------------- receive buffer ----------------
   logic                       rd_start, buf_wr;
   logic [RX_DEPTH*BYTE_W-1:0] buf_data, trim_data;
   logic [RCW-1:0]             buf_cnt, trim_len;

   hsk_rxbuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .clr(rd_start), .wr(buf_wr),
      .din(sh_rx_byte), .data(buf_data), .cnt(buf_cnt)
   );

   logic trim_hit;
   if (TRIM_EN) begin : g_trim_on
      assign trim_hit = (rq_data[BYTE_W-1:0] == TRIM_TYPE);
   end else begin : g_trim_off
      assign trim_hit = 1'b0;
   end

   hsk_trim #(.DEPTH(RX_DEPTH)) u_trim (
      .hit(trim_hit), .din(buf_data), .len(buf_cnt),
      .dout(trim_data), .lout(trim_len)
   );

   // ---------------- decisions ----------------
   logic acc, req_ok, retry, go_send, rdone_send, start_now, last_sent;

   assign acc      = req_start && !pend && sync_ok;
   assign req_ok   = (req_len >= RLW'(2)) && (req_len <= RLW'(REQ_MAX)) &&
                     (req_data[BYTE_W-1:0] <= MAX_TYPE);
   assign retry    = pend && !to_reply;
   assign go_send  = sync_ok && (st == ENG_IDLE) && !sh_done && pend && treq_n;
   assign rdone_send = sync_ok && (st == ENG_RDONE) && sh_done && retry && treq_n;
   assign start_now  = go_send || rdone_send;
   assign rd_start = sync_ok && sh_done &&
                     ((st == ENG_IDLE) || (st == ENG_AWAIT) ||
                      ((st == ENG_RDONE) && !treq_n));
   assign buf_wr   = sync_ok && sh_done && (st == ENG_READ);
   assign last_sent = (idx >= rq_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ENG_IDLE;
         pend       <= 1'b0;
         rq_rexp    <= 1'b0;
         to_reply   <= 1'b0;
         rq_data    <= '0;
         rq_len     <= '0;
         idx        <= '0;
         e_ack_n    <= 1'b1;
         e_tip_n    <= 1'b1;
         sh_dir_out <= 1'b0;
         sh_load    <= 1'b0;
         sh_tx_byte <= '0;
         done       <= 1'b0;
         done_err   <= 1'b0;
         uns_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_len    <= '0;
         uns_data   <= '0;
         uns_len    <= '0;
      end else begin
         sh_load   <= 1'b0;
         done      <= 1'b0;
         done_err  <= 1'b0;
         uns_valid <= 1'b0;

         if (acc) begin
            if (req_ok) begin
               pend    <= 1'b1;
               rq_data <= req_data;
               rq_len  <= req_len;
               rq_rexp <= req_reply;
            end else begin
               done     <= 1'b1;
               done_err <= 1'b1;
            end
         end

         if (sync_ok && sh_done) begin
            case (st)
               ENG_IDLE: begin
                  e_tip_n  <= 1'b0;
                  to_reply <= 1'b0;
                  st       <= ENG_READ;
               end
               ENG_AWAIT: begin
                  e_tip_n  <= 1'b0;
                  to_reply <= 1'b1;
                  st       <= ENG_READ;
               end
               ENG_FIRST, ENG_SEND: begin
                  if ((st == ENG_FIRST) && !treq_n) begin
                     sh_dir_out <= 1'b0;
                     e_tip_n    <= 1'b1;
                     e_ack_n    <= 1'b1;
                     st         <= ENG_IDLE;
                  end else if ((st == ENG_SEND) && last_sent) begin
                     sh_dir_out <= 1'b0;
                     e_tip_n    <= 1'b1;
                     e_ack_n    <= 1'b1;
                     if (rq_rexp) begin
                        st <= ENG_AWAIT;
                     end else begin
                        done <= 1'b1;
                        pend <= 1'b0;
                        st   <= ENG_IDLE;
                     end
                  end else begin
                     sh_load    <= 1'b1;
                     sh_tx_byte <= rq_data[{idx, 3'b000} +: BYTE_W];
                     idx        <= idx + RLW'(1);
                     e_ack_n    <= !e_ack_n;
                     st         <= ENG_SEND;
                  end
               end
               ENG_READ: begin
                  if (treq_n) begin
                     e_tip_n <= 1'b1;
                     e_ack_n <= 1'b1;
                     st      <= ENG_RDONE;
                  end else begin
                     e_ack_n <= !e_ack_n;
                  end
               end
               ENG_RDONE: begin
                  if (to_reply) begin
                     rsp_data <= trim_data;
                     rsp_len  <= trim_len;
                     done     <= 1'b1;
                     pend     <= 1'b0;
                  end else begin
                     uns_data  <= buf_data;
                     uns_len   <= buf_cnt;
                     uns_valid <= 1'b1;
                  end
                  to_reply <= 1'b0;
                  if (!treq_n) begin
                     e_tip_n <= 1'b0;
                     st      <= ENG_READ;
                  end else begin
                     st      <= ENG_IDLE;
                  end
               end
               default: st <= ENG_IDLE;
            endcase
         end

         if (start_now) begin
            sh_dir_out <= 1'b1;
            sh_load    <= 1'b1;
            sh_tx_byte <= rq_data[BYTE_W-1:0];
            e_tip_n    <= 1'b0;
            idx        <= RLW'(1);
            st         <= ENG_FIRST;
         end
      end
   end

   assign req_busy = pend;
   assign ack_n    = sync_ok ? e_ack_n : sy_ack_n;
   assign tip_n    = sync_ok ? e_tip_n : 1'b1;
endmodule

// File: rtl/hsk_xfer_chk.sv
module hsk_xfer_chk #(
   parameter int RX_DEPTH = 16,
   localparam int RCW = $clog2(RX_DEPTH + 1)
)(
   input logic           clk,
   input logic           rst_n,
   input logic           req_busy,
   input logic           done,
   input logic           done_err,
   input logic           uns_valid,
   input logic [RCW-1:0] rsp_len,
   input logic [RCW-1:0] uns_len,
   input logic           ack_n,
   input logic           tip_n,
   input logic           sh_dir_out,
   input logic           sh_load,
   input logic           sync_ok,
   input logic           sync_fail
);
   p_no_tip_before_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_ok |-> tip_n);

   p_fail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_fail |-> (tip_n && ack_n && !sync_ok));

   p_reject_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> !req_busy);

   p_load_outward_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sh_load |-> (sh_dir_out && !tip_n));

   p_load_toggles_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_load && $past(!tip_n)) |-> (ack_n != $past(ack_n)));

   p_done_dir_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_err) |-> !sh_dir_out);

   p_single_completion_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && uns_valid));

   p_len_capped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_len <= RCW'(RX_DEPTH)) && (uns_len <= RCW'(RX_DEPTH)));
endmodule

bind hsk_xfer_engine hsk_xfer_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_busy(req_busy), .done(done),
   .done_err(done_err), .uns_valid(uns_valid), .rsp_len(rsp_len),
   .uns_len(uns_len), .ack_n(ack_n), .tip_n(tip_n),
   .sh_dir_out(sh_dir_out), .sh_load(sh_load), .sync_ok(sync_ok),
   .sync_fail(sync_fail)
);

// File: tb/hsk_xfer_engine_bench.sv
module hsk_xfer_engine_bench;
   localparam int REQ_MAX  = 8;
   localparam int RX_DEPTH = 16;
   localparam int SETTLE_T = 20;
   localparam int TMO_T    = 300;
   localparam int RLW      = $clog2(REQ_MAX + 1);
   localparam int RCW      = $clog2(RX_DEPTH + 1);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     req_start = 1'b0;
   logic [REQ_MAX*8-1:0]     req_data = '0;
   logic [RLW-1:0]           req_len = '0;
   logic                     req_reply = 1'b0;
   logic                     req_busy, done, done_err, uns_valid;
   logic [RX_DEPTH*8-1:0]    rsp_data, uns_data;
   logic [RCW-1:0]           rsp_len, uns_len;
   logic                     treq_n = 1'b1;
   logic                     ack_n, tip_n, sh_dir_out, sh_load;
   logic [7:0]               sh_tx_byte;
   logic                     sh_done = 1'b0;
   logic [7:0]               sh_rx_byte = '0;
   logic                     sync_ok, sync_fail;

   always #5 clk = ~clk;

   hsk_xfer_engine #(.REQ_MAX(REQ_MAX), .RX_DEPTH(RX_DEPTH),
                     .SETTLE_CYC(SETTLE_T), .TMO_CYC(TMO_T)) u_hsk_xfer_engine (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_data(req_data),
      .req_len(req_len), .req_reply(req_reply), .req_busy(req_busy),
      .done(done), .done_err(done_err), .rsp_data(rsp_data), .rsp_len(rsp_len),
      .uns_valid(uns_valid), .uns_data(uns_data), .uns_len(uns_len),
      .treq_n(treq_n), .ack_n(ack_n), .tip_n(tip_n), .sh_dir_out(sh_dir_out),
      .sh_load(sh_load), .sh_tx_byte(sh_tx_byte), .sh_done(sh_done),
      .sh_rx_byte(sh_rx_byte), .sync_ok(sync_ok), .sync_fail(sync_fail)
   );

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic [7:0] tb_req [REQ_MAX];
   logic [7:0] tb_rx  [20];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // one byte-done event; returns at the negedge after the sampling edge
   task automatic pulse(input logic [7:0] b, input logic tr);
      treq_n     = tr;
      sh_rx_byte = b;
      sh_done    = 1'b1;
      tick();
      sh_done    = 1'b0;
   endtask

   task automatic issue(input int len, input bit rexp);
      for (int i = 0; i < REQ_MAX; i++) req_data[i*8 +: 8] = tb_req[i];
      req_len   = RLW'(len);
      req_reply = rexp;
      req_start = 1'b1;
      tick();
      req_start = 1'b0;
   endtask

   // full outbound transfer with no collision
   task automatic send_pkt(input int len, input bit rexp);
      logic prev;
      issue(len, rexp);
      tick();
      chk(sh_load && sh_dir_out && !tip_n, "R5 start", {sh_load, sh_dir_out, tip_n}, 3'b110);
      chk(sh_tx_byte == tb_req[0], "R5 byte0", sh_tx_byte, tb_req[0]);
      for (int i = 1; i < len; i++) begin
         prev = ack_n;
         pulse(8'h00, 1'b1);
         chk(sh_load && sh_tx_byte == tb_req[i], "R6 next byte", sh_tx_byte, tb_req[i]);
         chk(ack_n != prev, "R6 ack toggle", ack_n, !prev);
      end
      pulse(8'h00, 1'b1);
      chk(tip_n && ack_n && !sh_dir_out, "R8 end lines", {tip_n, ack_n, sh_dir_out}, 3'b110);
      if (!rexp) begin
         chk(done && !done_err && !req_busy, "R8 complete", {done, done_err, req_busy}, 3'b100);
      end
   endtask

   // packet body: stores n bytes from tb_rx, last one with request released
   task automatic read_body(input int n);
      logic prev;
      for (int i = 0; i < n; i++) begin
         prev = ack_n;
         pulse(tb_rx[i], (i == n - 1));
         if (i < n - 1) chk(ack_n != prev && !tip_n, "R9 read ack toggle", ack_n, !prev);
         else           chk(ack_n && tip_n, "R9 read end", {ack_n, tip_n}, 2'b11);
      end
   endtask

   task automatic read_pkt(input int n);
      pulse(8'hEE, 1'b0);
      chk(!tip_n && !sh_dir_out, "R10 read begins", tip_n, 0);
      read_body(n);
   endtask

   task automatic t_reset();
      chk(ack_n && tip_n && !sh_dir_out && !req_busy && !done && !uns_valid &&
          !sync_ok && !sync_fail, "R1 reset state", {ack_n, tip_n, sync_ok}, 3'b110);
   endtask

   task automatic t_sync();
      int c = 0;
      rst_n = 1'b1;
      while (ack_n && c < 200) begin
         tick();
         c++;
         if (!tip_n || sync_ok) chk(0, "R2 quiet settle", tip_n, 1);
      end
      chk(!ack_n && c >= SETTLE_T - 2, "R2 ack after settle", c, SETTLE_T);
      pulse(8'h00, 1'b0);
      chk(ack_n && !sync_ok, "R2 ack released", ack_n, 1);
      pulse(8'h00, 1'b1);
      tick();
      chk(sync_ok && tip_n, "R2 sync ready", sync_ok, 1);
   endtask

   task automatic t_invalid();
      tb_req[0] = 8'h01; tb_req[1] = 8'h05;
      issue(1, 1'b0);
      chk(done && done_err && !req_busy, "R4 short", {done, done_err, req_busy}, 3'b110);
      tb_req[0] = 8'h02;
      issue(3, 1'b0);
      chk(done && done_err && !req_busy, "R4 bad type", {done, done_err, req_busy}, 3'b110);
      tb_req[0] = 8'h01;
      issue(9, 1'b0);
      chk(done && done_err && !req_busy, "R4 too long", {done, done_err, req_busy}, 3'b110);
      tick();
      chk(tip_n && !sh_load, "R4 no transfer", tip_n, 1);
   endtask

   task automatic t_plain();
      tb_req[0] = 8'h01; tb_req[1] = 8'hA5; tb_req[2] = 8'h3C; tb_req[3] = 8'h77;
      send_pkt(4, 1'b0);
   endtask

   task automatic t_reply(input logic [7:0] typ, input int n, input int exp_len,
                          input int skip, input string tag);
      tb_req[0] = typ; tb_req[1] = 8'h2C;
      send_pkt(2, 1'b1);
      chk(req_busy && !done, {tag, " awaiting"}, req_busy, 1);
      read_pkt(n);
      pulse(8'hEE, 1'b1);
      chk(done && !done_err && !req_busy, {tag, " done"}, {done, done_err, req_busy}, 3'b100);
      chk(rsp_len == RCW'(exp_len), {tag, " length"}, rsp_len, exp_len);
      for (int i = 0; i < exp_len; i++)
         chk(rsp_data[i*8 +: 8] == tb_rx[i + skip], {tag, " data"}, rsp_data[i*8 +: 8], tb_rx[i + skip]);
   endtask

   task automatic t_unsol();
      for (int i = 0; i < 4; i++) tb_rx[i] = 8'h90 + 8'(i);
      read_pkt(4);
      pulse(8'hEE, 1'b1);
      chk(uns_valid && !done && uns_len == RCW'(4), "R10 unsolicited", uns_len, 4);
      for (int i = 0; i < 4; i++)
         chk(uns_data[i*8 +: 8] == tb_rx[i], "R10 data", uns_data[i*8 +: 8], tb_rx[i]);
   endtask

   task automatic t_cap();
      for (int i = 0; i < 18; i++) tb_rx[i] = 8'h40 + 8'(i);
      read_pkt(18);
      pulse(8'hEE, 1'b1);
      chk(uns_valid && uns_len == RCW'(RX_DEPTH), "R11 capped length", uns_len, RX_DEPTH);
      chk(uns_data[15*8 +: 8] == 8'h4F, "R11 last kept byte", uns_data[15*8 +: 8], 8'h4F);
   endtask

   task automatic t_collision();
      logic prev;
      tb_req[0] = 8'h01; tb_req[1] = 8'h10; tb_req[2] = 8'h20;
      issue(3, 1'b0);
      tick();
      chk(sh_load && sh_tx_byte == 8'h01, "R5 start before collision", sh_tx_byte, 8'h01);
      pulse(8'h00, 1'b0);
      chk(tip_n && ack_n && !sh_dir_out && req_busy, "R7 collision abort",
          {tip_n, ack_n, sh_dir_out, req_busy}, 4'b1101);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(!sh_load && tip_n, "R5 held while request low", sh_load, 0);
      end
      tb_rx[0] = 8'hAA; tb_rx[1] = 8'hBB;
      read_pkt(2);
      pulse(8'hEE, 1'b1);
      chk(uns_valid && uns_len == RCW'(2), "R13 packet before retry", uns_len, 2);
      chk(sh_load && sh_tx_byte == 8'h01 && !tip_n && sh_dir_out, "R13 retry from byte 0",
          sh_tx_byte, 8'h01);
      for (int i = 1; i < 3; i++) begin
         prev = ack_n;
         pulse(8'h00, 1'b1);
         chk(sh_load && sh_tx_byte == tb_req[i] && ack_n != prev, "R7 retry bytes",
             sh_tx_byte, tb_req[i]);
      end
      pulse(8'h00, 1'b1);
      chk(done && !done_err && !req_busy, "R7 retry completes", {done, req_busy}, 2'b10);
   endtask

   task automatic t_back_to_back();
      tb_rx[0] = 8'h11;
      read_pkt(1);
      pulse(8'hEE, 1'b0);
      chk(uns_valid && uns_len == RCW'(1) && !tip_n, "R13 next packet at once",
          {uns_valid, tip_n}, 2'b10);
      tb_rx[0] = 8'h22; tb_rx[1] = 8'h33;
      read_body(2);
      pulse(8'hEE, 1'b1);
      chk(uns_valid && uns_len == RCW'(2) && uns_data[15:0] == 16'h3322, "R13 second packet",
          uns_data[15:0], 16'h3322);
   endtask

   task automatic t_timeout();
      rst_n = 1'b0;
      treq_n = 1'b1;
      tick();
      rst_n = 1'b1;
      repeat (SETTLE_T + TMO_T + 20) tick();
      chk(sync_fail && !sync_ok && ack_n && tip_n, "R3 sync timeout",
          {sync_fail, sync_ok, ack_n, tip_n}, 4'b1011);
   endtask

   initial begin
      for (int i = 0; i < REQ_MAX; i++) tb_req[i] = '0;
      for (int i = 0; i < 20; i++) tb_rx[i] = '0;
      repeat (3) tick();
      t_reset();
      t_sync();
      t_invalid();
      t_plain();
      // R12: trimmed bus-packet reply, five bytes, strip two
      tb_rx[0] = 8'h00; tb_rx[1] = 8'h00; tb_rx[2] = 8'h5A; tb_rx[3] = 8'h6B; tb_rx[4] = 8'h7C;
      t_reply(8'h00, 5, 3, 2, "R12 strip");
      tb_rx[0] = 8'h00; tb_rx[1] = 8'h02; tb_rx[2] = 8'h11; tb_rx[3] = 8'h22;
      t_reply(8'h00, 4, 0, 0, "R12 no-response bit");
      tb_rx[0] = 8'h00; tb_rx[1] = 8'h00;
      t_reply(8'h00, 2, 0, 0, "R12 short");
      tb_rx[0] = 8'h01; tb_rx[1] = 8'h07; tb_rx[2] = 8'h99;
      t_reply(8'h01, 3, 3, 0, "R9 R12 untrimmed");
      t_unsol();
      t_cap();
      t_collision();
      t_back_to_back();
      t_timeout();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule